// File: doc/BRIEF.md
# DMA Request Trigger and Byte-Count Reload Slice

This block is the per-channel control slice of a DMA controller. It takes a raw transfer-request line from outside the clock domain and passes it through a synchroniser. It then recognises the request in one of four programmable ways: a rising edge, a falling edge, a high level or a low level. When a request is recognised and the channel may run, the block issues a one-cycle grant. Rising-edge sensing suits software triggers and external request pins. Falling-edge sensing suits on-chip peripheral sources.

The slice also keeps a current byte counter. Each transfer-done strobe reports how many bytes were moved, and the counter drops by that amount, stopping at zero. When a done strobe brings a nonzero count to zero, the block pulses an end-of-transfer flag. If reload is enabled, it refills the counter from a reload register, so transfers can repeat without software. If reload is disabled, the counter stays at zero and granting stops until software writes a fresh count.

Software reaches the block through a small register port with three locations: control, reload count and current count.

Top module: `dma_trigger_slice`

## Requirements
- R1: With sense field 00 (control bits 17:16) and the channel enabled, each rising edge of the synchronised request produces exactly one grant pulse; holding the request high produces no further grants.
- R2: With sense field 10, each falling edge of the request produces exactly one grant pulse; rising edges produce none.
- R3: With sense field 01, a grant is issued on every cycle that the synchronised request is high and the channel is active, and no grant is issued while it is low.
- R4: With sense field 11, a grant is issued on every cycle that the synchronised request is low and the channel is active, and no grant is issued while it is high.
- R5: A qualifying edge that arrives while the channel cannot grant (current count zero) is held pending, and exactly one grant follows once the channel becomes active.
- R6: The request passes through two synchroniser flops before sensing, so in high-level mode the first grant appears on the third rising clock edge after the raw request rises.
- R7: The control word (address 0) holds channel enable at bit 0, reload enable at bit 10 and the sense field at bits 17:16. All other bits, including the reserved bits 23:18 and 15:11, ignore writes and read as zero.
- R8: Each transfer-done strobe lowers the current count by the reported byte amount, saturating at zero.
- R9: When a done strobe takes a nonzero count to zero, the end flag is high for exactly the next cycle. A done strobe on a count that is already zero raises no end flag.
- R10: When reload enable is 1 and the end condition occurs, the current count is loaded from the reload register instead of zero.
- R11: When reload enable is 0 and the end condition occurs, the count stays at zero and grants stop until software writes a nonzero count.
- R12: The registers read back one cycle after the address is presented: address 0 control, 1 reload count, 2 current count, 3 zero. All of them read zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| req_in | input | 1 | Raw asynchronous transfer request |
| xfer_done | input | 1 | Transfer-done strobe |
| xfer_bytes | input | SIZE_W | Bytes moved by the completed transfer |
| grant | output | 1 | One-cycle transfer grant |
| xfer_end | output | 1 | End-of-transfer pulse |

## Verification
The bench drives a done amount larger than the remaining count. A counter that wrapped instead of saturating would read back a huge value and miss the end pulse. It also fires an edge while the count is zero and then writes a count: a design that dropped the edge would give no grant, and one that did not clear the pending request would give several. It measures the first level-mode grant to the exact cycle, which exposes a missing or extra synchroniser stage. It also checks that done strobes on an already empty counter neither pulse the end flag nor trigger a reload, and that a non-reloading channel stops granting at the end and resumes once a new count is written.

// File: rtl/dma_trig_pkg.sv
package dma_trig_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RELOAD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_COUNT  = 2'd2;

  // control word field positions
  localparam int EN_BIT     = 0;
  localparam int RELOAD_BIT = 10;
  localparam int SENSE_LSB  = 16;

  typedef enum logic [1:0] {
    SENSE_RISE = 2'b00,
    SENSE_HIGH = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_LOW  = 2'b11
  } sense_e;

endpackage

// File: rtl/dma_trig_regs.sv
module dma_trig_regs
  import dma_trig_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] count_val,
  output logic [DATA_W-1:0] rdata,
  output logic              chan_en,
  output logic              reload_en,
  output sense_e            sense,
  output logic [DATA_W-1:0] reload_val,
  output logic              ctrl_wr,
  output logic              count_wr
);

  localparam logic [DATA_W-1:0] ONE       = DATA_W'(1);
  localparam logic [DATA_W-1:0] CTRL_MASK = (ONE << EN_BIT) | (ONE << RELOAD_BIT)
                                          | (DATA_W'(3) << SENSE_LSB);

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic              reload_wr;

  assign ctrl_wr   = wr_en && (addr == ADDR_CTRL);
  assign reload_wr = wr_en && (addr == ADDR_RELOAD);
  assign count_wr  = wr_en && (addr == ADDR_COUNT);

  // only implemented fields are stored; everything else stays zero
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (ctrl_wr)   ctrl_q   <= wdata & CTRL_MASK;
      if (reload_wr) reload_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        ADDR_CTRL:   rdata <= ctrl_q;
        ADDR_RELOAD: rdata <= reload_q;
        ADDR_COUNT:  rdata <= count_val;
        default:     rdata <= '0;
      endcase
    end
  end

  assign chan_en    = ctrl_q[EN_BIT];
  assign reload_en  = ctrl_q[RELOAD_BIT];
  assign sense      = sense_e'(ctrl_q[SENSE_LSB +: 2]);
  assign reload_val = reload_q;

endmodule

// File: rtl/dma_trig_sense.sv
module dma_trig_sense
  import dma_trig_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   req_raw,
  input  sense_e mode,
  input  logic   clr,
  input  logic   take,
  output logic   want
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pend_q;
  logic                   req_s;
  logic                   rise, fall, edge_hit, level_hit, edge_mode;

  // synchroniser chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) sync_q[i] <= 1'b0;
      else     sync_q[i] <= (i == 0) ? req_raw : sync_q[(i == 0) ? 0 : i-1];
    end
  end

  assign req_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= req_s;
  end

  assign rise = req_s & ~prev_q;
  assign fall = ~req_s & prev_q;

  always_comb begin
    edge_hit  = 1'b0;
    level_hit = 1'b0;
    edge_mode = 1'b0;
    case (mode)
      SENSE_RISE: begin edge_mode = 1'b1; edge_hit = rise; end
      SENSE_FALL: begin edge_mode = 1'b1; edge_hit = fall; end
      SENSE_HIGH: level_hit = req_s;
      SENSE_LOW:  level_hit = ~req_s;
      default:    level_hit = 1'b0;
    endcase
  end

  // one pending request per edge, held until the channel takes it
  always_ff @(posedge clk) begin
    if (rst || clr) pend_q <= 1'b0;
    else            pend_q <= edge_hit | (pend_q & ~take);
  end

  assign want = edge_mode ? pend_q : level_hit;

  p_pending_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !take && !clr) |=> pend_q);

endmodule

// File: rtl/dma_trig_counter.sv
module dma_trig_counter #(
  parameter int DATA_W = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cur,
  input  logic [DATA_W-1:0] wdata,
  input  logic              done,
  input  logic [SIZE_W-1:0] bytes,
  input  logic              reload_en,
  input  logic [DATA_W-1:0] reload_val,
  output logic [DATA_W-1:0] count_q,
  output logic              end_q
);

  localparam int PAD_W = DATA_W + 1 - SIZE_W;

  logic [DATA_W:0]   diff;
  logic [DATA_W-1:0] nxt;
  logic              end_hit;

  assign diff    = {1'b0, count_q} - {{PAD_W{1'b0}}, bytes};
  assign nxt     = diff[DATA_W] ? '0 : diff[DATA_W-1:0];
  assign end_hit = done && (count_q != '0) && (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      end_q   <= 1'b0;
    end else begin
      end_q <= end_hit && !wr_cur;
      if (wr_cur)       count_q <= wdata;
      else if (end_hit) count_q <= reload_en ? reload_val : '0;
      else if (done)    count_q <= nxt;
    end
  end

  p_no_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(wr_cur) && !$past(end_hit && reload_en)) |-> (count_q <= $past(count_q)));

  p_end_from_done_r9: assert property (@(posedge clk) disable iff (rst)
    end_q |-> ($past(done) && ($past(count_q) != '0)));

  p_reload_load_r10: assert property (@(posedge clk) disable iff (rst)
    (end_hit && reload_en && !wr_cur) |=> (count_q == $past(reload_val)));

  p_zero_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (end_hit && !reload_en && !wr_cur) |=> (count_q == '0));

endmodule

// File: rtl/dma_trigger_slice.sv
module dma_trigger_slice
  import dma_trig_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SIZE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              req_in,
  input  logic              xfer_done,
  input  logic [SIZE_W-1:0] xfer_bytes,
  output logic              grant,
  output logic              xfer_end
);

  logic              chan_en, reload_en, ctrl_wr, count_wr;
  sense_e            sense;
  logic [DATA_W-1:0] reload_val, count_q;
  logic              want, active;

  dma_trig_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .count_val (count_q),
    .rdata     (reg_rdata),
    .chan_en   (chan_en),
    .reload_en (reload_en),
    .sense     (sense),
    .reload_val(reload_val),
    .ctrl_wr   (ctrl_wr),
    .count_wr  (count_wr)
  );

  dma_trig_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
    .clk    (clk),
    .rst    (rst),
    .req_raw(req_in),
    .mode   (sense),
    .clr    (ctrl_wr),
    .take   (active),
    .want   (want)
  );

  dma_trig_counter #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) u_count (
    .clk       (clk),
    .rst       (rst),
    .wr_cur    (count_wr),
    .wdata     (reg_wdata),
    .done      (xfer_done),
    .bytes     (xfer_bytes),
    .reload_en (reload_en),
    .reload_val(reload_val),
    .count_q   (count_q),
    .end_q     (xfer_end)
  );

  // channel may grant only while enabled with bytes left
  assign active = chan_en && (count_q != '0);

  always_ff @(posedge clk) begin
    if (rst) grant <= 1'b0;
    else     grant <= active & want;
  end

  p_halt_after_end_r11: assert property (@(posedge clk) disable iff (rst)
    (xfer_end && !reload_en && !$past(reg_wr) && !(reg_wr && reg_addr == ADDR_COUNT))
      |=> !grant);

endmodule

// File: tb/dma_trigger_slice_bench.sv
module dma_trigger_slice_bench;
  localparam int DW = 32;
  localparam int SW = 16;

  typedef struct packed {
    logic        rel;
    logic [15:0] bytes;
    logic [31:0] exp_cnt;
    logic        exp_end;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b1, 16'd30,  32'd70, 1'b0},
    '{1'b1, 16'd50,  32'd20, 1'b0},
    '{1'b1, 16'd25,  32'd40, 1'b1},
    '{1'b1, 16'd1,   32'd39, 1'b0},
    '{1'b0, 16'd39,  32'd0,  1'b1},
    '{1'b0, 16'd5,   32'd0,  1'b0},
    '{1'b1, 16'd200, 32'd0,  1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          req_in = 1'b0;
  logic          xfer_done = 1'b0;
  logic [SW-1:0] xfer_bytes = '0;
  logic          grant, xfer_end;

  int n_chk = 0, n_bad = 0, gcnt = 0;

  always #2 clk = ~clk;

  dma_trigger_slice u_dma_trigger_slice (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_in(req_in),
    .xfer_done(xfer_done), .xfer_bytes(xfer_bytes),
    .grant(grant), .xfer_end(xfer_end)
  );

  always @(negedge clk) if (grant) gcnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse_req();
    @(negedge clk); req_in = 1'b1;
    repeat (4) @(negedge clk);
    req_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic done_strobe(input logic [15:0] b);
    @(negedge clk); xfer_done = 1'b1; xfer_bytes = b;
    @(negedge clk); xfer_done = 1'b0; xfer_bytes = '0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12 reset state
    check("R12 grant after reset", 32'(grant), 0);
    check("R9 end after reset", 32'(xfer_end), 0);
    rd(2'd0, v); check("R12 ctrl reset", v, 0);
    rd(2'd1, v); check("R12 reload reset", v, 0);
    rd(2'd2, v); check("R12 count reset", v, 0);

    // R7 reserved bits
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R7 ctrl readback masks reserved", v, 32'h0003_0401);
    wr(2'd0, 32'h0);
    rd(2'd3, v); check("R12 unused address reads zero", v, 0);

    // R8 R9 R10 R11 vector walk
    wr(2'd1, 32'd40);
    rd(2'd1, v); check("R12 reload readback", v, 40);
    wr(2'd2, 32'd100);
    foreach (VECS[i]) begin
      wr(2'd0, 32'(VECS[i].rel) << 10);
      @(negedge clk); xfer_done = 1'b1; xfer_bytes = VECS[i].bytes;
      @(negedge clk); xfer_done = 1'b0; xfer_bytes = '0;
      check($sformatf("R9 end flag vec%0d", i), 32'(xfer_end), 32'(VECS[i].exp_end));
      @(negedge clk);
      check($sformatf("R9 end flag one cycle vec%0d", i), 32'(xfer_end), 0);
      rd(2'd2, v);
      check($sformatf("R8 R10 count vec%0d", i), v, VECS[i].exp_cnt);
    end

    // R1 rising edge
    wr(2'd2, 32'd1000);
    wr(2'd0, 32'h0000_0001);
    base = gcnt;
    repeat (3) pulse_req();
    repeat (6) @(negedge clk);
    check("R1 one grant per rising edge", 32'(gcnt - base), 3);

    // R2 falling edge
    wr(2'd0, 32'h0002_0001);
    base = gcnt;
    repeat (3) pulse_req();
    repeat (6) @(negedge clk);
    check("R2 one grant per falling edge", 32'(gcnt - base), 3);

    // R6 latency and R3 high level
    wr(2'd0, 32'h0001_0001);
    repeat (4) @(negedge clk);
    base = gcnt;
    req_in = 1'b1;
    @(negedge clk); check("R6 no grant after 1 edge", 32'(grant), 0);
    @(negedge clk); check("R6 no grant after 2 edges", 32'(grant), 0);
    @(negedge clk); check("R6 grant after 3 edges", 32'(grant), 1);
    repeat (7) @(negedge clk);
    req_in = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 grant every high cycle", 32'(gcnt - base), 10);
    check("R3 no grant when low", 32'(grant), 0);

    // R4 low level
    wr(2'd0, 32'h0003_0001);
    repeat (4) @(negedge clk);
    check("R4 grant while low", 32'(grant), 1);
    req_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R4 no grant while high", 32'(grant), 0);
    wr(2'd0, 32'h0);
    req_in = 1'b0;
    repeat (4) @(negedge clk);

    // R5 pending edge held while count is zero
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h0000_0001);
    base = gcnt;
    pulse_req();
    repeat (4) @(negedge clk);
    check("R5 no grant while count zero", 32'(gcnt - base), 0);
    wr(2'd2, 32'd7);
    repeat (5) @(negedge clk);
    check("R5 single grant once active", 32'(gcnt - base), 1);

    // R11 stop at end without reload, resume on new count
    wr(2'd0, 32'h0001_0001);
    wr(2'd2, 32'd10);
    req_in = 1'b1;
    repeat (5) @(negedge clk);
    check("R11 granting before end", 32'(grant), 1);
    done_strobe(16'd10);
    check("R9 end at count zero", 32'(xfer_end), 1);
    repeat (3) @(negedge clk);
    check("R11 grants stop after end", 32'(grant), 0);
    rd(2'd2, v); check("R11 count held at zero", v, 0);
    wr(2'd2, 32'd5);
    repeat (3) @(negedge clk);
    check("R11 grants resume after new count", 32'(grant), 1);
    req_in = 1'b0;
    wr(2'd0, 32'h0);
    repeat (4) @(negedge clk);

    finish_run();
  end

endmodule